// File: doc/BRIEF.md
# DMA Channel Register Bank with Write Protection

This block holds the programming state of a small multi-channel DMA controller: for each channel a control word (enable, pending request, mode), a source address, a destination address and a transfer count, plus one interrupt status word shared by all channels and a sticky protection-violation word. A processor reaches it over a plain register port: address, write data, write strobe and a combinational read-data return. The DMA engine can also write into the bank through a second port. That port carries the index of the channel making the transfer, so one channel can reload another channel's addresses.

Neither write port is a stream. Each write completes in the cycle its strobe is high and can never be held off, so neither port has valid/ready or back-pressure. Which writes take effect depends on the target channel's enable bit as it stands in the cycle of the write. The count is locked while the channel is enabled. Processor writes to the address and mode fields of an enabled channel are dropped and flagged. A channel can never write its own registers through the DMA port. Pending requests and interrupt bits are raised by hardware event inputs and cleared by writing 0.

Top module: `dma_reg_bank`

## Requirements
- R1: After reset every enable bit, request flag, mode field, source, destination, count, interrupt status bit and protection bit reads 0.
- R2: Channel c occupies addresses 4c to 4c+3: control at 4c, source at 4c+1, destination at 4c+2, count at 4c+3. In the control word bit 0 is the enable, bit 1 the request flag and bits 4:2 the mode (with the default mode width of 3). While a channel is disabled, all four of its registers take processor writes and read back the written value.
- R3: The enable bit takes the written value on every control write, whether the channel is enabled or not, and `ch_enable` follows it one cycle later.
- R4: While a channel is enabled, a write to its count register from either port leaves the count unchanged and raises no flag.
- R5: While a channel is enabled, a processor write to its source or destination leaves the register unchanged and sets protection bit 0. A processor control write whose mode field differs from the stored mode keeps the stored mode and sets protection bit 0.
- R6: A pulse on `req_set[c]` sets request flag c. Writing 0 to control bit 1 clears the flag and writing 1 leaves it unchanged. When a set and a clear arrive in the same cycle, the set wins.
- R7: The interrupt status word at address 4·NCH holds one bit per channel. A pulse on `irq_set[c]` sets bit c. A written 0 clears a bit and a written 1 keeps it. The set wins over a same-cycle clear. `irq_pending` is high when any bit is set.
- R8: A DMA-port write issued by channel s to the source or destination of a different channel c takes effect even while c is enabled.
- R9: A DMA-port write that targets any register of the channel named on `dma_ch` is dropped and sets protection bit 1.
- R10: The protection word at address 4·NCH+1 keeps bits 0 and 1 until a write of 0 to that bit clears it. A same-cycle violation sets the bit regardless of the clear.
- R11: When both ports write the same register in one cycle, the DMA-port value is stored. DMA-port writes to a control or count register of another channel follow the enable rules without flagging. DMA-port writes to the status or protection words are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | AW | Processor register address |
| cpu_wdata | input | REG_W | Processor write data |
| cpu_we | input | 1 | Processor write strobe |
| cpu_rdata | output | REG_W | Read data for `cpu_addr`, combinational |
| dma_addr | input | AW | DMA-port register address |
| dma_wdata | input | REG_W | DMA-port write data |
| dma_we | input | 1 | DMA-port write strobe |
| dma_ch | input | CW | Index of the channel performing the DMA-port write |
| req_set | input | NCH | Per-channel hardware request events |
| irq_set | input | NCH | Per-channel interrupt events |
| ch_enable | output | NCH | Per-channel enable bits |
| ch_request | output | NCH | Per-channel pending request flags |
| irq_pending | output | 1 | OR of the interrupt status bits |

## Verification
The functions that can fall in the same cycle are a hardware set event and a software write of 0 to the same request flag, interrupt status bit or protection bit. The bench provokes this on purpose: it pulses `req_set` or `irq_set` in the very cycle the processor clears that bit, and it makes a DMA self-write coincide with a write of 0 to the protection word. It judges the outcome by reading the bit back, which must still be set. A random phase then lets events, clears and writes from both ports overlap freely, and a behavioural model compares every visible value against the design on every clock.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;

  localparam int REGS_PER_CH = 4;

  typedef enum logic [1:0] {
    SEL_CTL = 2'd0,
    SEL_SRC = 2'd1,
    SEL_DST = 2'd2,
    SEL_CNT = 2'd3
  } reg_sel_e;

  localparam int CTL_EN_BIT   = 0;
  localparam int CTL_REQ_BIT  = 1;
  localparam int CTL_MODE_LSB = 2;

  localparam int PROT_CPU_BIT = 0;
  localparam int PROT_DMA_BIT = 1;
  localparam int PROT_W       = 2;

endpackage

// File: rtl/dmarb_decode.sv
module dmarb_decode
  import dmarb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 5,
  parameter int CW  = 2
) (
  input  logic [AW-1:0] addr,
  output logic          ch_hit,
  output logic [CW-1:0] ch,
  output reg_sel_e      sel,
  output logic          irq_hit,
  output logic          prot_hit
);

  localparam int CH_SPAN   = NCH * REGS_PER_CH;
  localparam int IRQ_ADDR  = CH_SPAN;
  localparam int PROT_ADDR = CH_SPAN + 1;

  logic [AW-1:0] ch_field;

  always_comb begin
    ch_field = addr >> 2;
    ch_hit   = (int'(addr) < CH_SPAN);
    ch       = ch_field[CW-1:0];
    sel      = reg_sel_e'(addr[1:0]);
    irq_hit  = (addr == AW'(IRQ_ADDR));
    prot_hit = (addr == AW'(PROT_ADDR));
  end

endmodule

// File: rtl/dmarb_channel.sv
module dmarb_channel
  import dmarb_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int REG_W  = 16,
  parameter int MODE_W = 3,
  parameter int CW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  reg_sel_e          cpu_sel,
  input  logic [REG_W-1:0]  cpu_wdata,
  input  logic              dma_wr,
  input  reg_sel_e          dma_sel,
  input  logic [REG_W-1:0]  dma_wdata,
  input  logic [CW-1:0]     dma_ch,
  input  logic              req_set,
  output logic              en,
  output logic              req,
  output logic [MODE_W-1:0] mode,
  output logic [REG_W-1:0]  src,
  output logic [REG_W-1:0]  dst,
  output logic [REG_W-1:0]  cnt,
  output logic              cpu_viol,
  output logic              dma_blk
);

  logic              self_hit;
  logic              dma_ok;
  logic [3:0]        d_hit;
  logic [3:0]        c_hit;
  logic              ctl_we;
  logic              ctl_en_w;
  logic              ctl_req_w;
  logic [MODE_W-1:0] ctl_mode_w;
  logic [MODE_W-1:0] cpu_mode_w;

  always_comb begin
    self_hit = dma_wr && (dma_ch == CW'(IDX));
    dma_ok   = dma_wr && !self_hit;
    for (int r = 0; r < 4; r++) begin
      d_hit[r] = dma_ok && (dma_sel == reg_sel_e'(r));
      c_hit[r] = cpu_wr && (cpu_sel == reg_sel_e'(r)) && !d_hit[r];
    end
  end

  always_comb begin
    ctl_we     = d_hit[SEL_CTL] || c_hit[SEL_CTL];
    cpu_mode_w = cpu_wdata[CTL_MODE_LSB +: MODE_W];
    if (d_hit[SEL_CTL]) begin
      ctl_en_w   = dma_wdata[CTL_EN_BIT];
      ctl_req_w  = dma_wdata[CTL_REQ_BIT];
      ctl_mode_w = dma_wdata[CTL_MODE_LSB +: MODE_W];
    end else begin
      ctl_en_w   = cpu_wdata[CTL_EN_BIT];
      ctl_req_w  = cpu_wdata[CTL_REQ_BIT];
      ctl_mode_w = cpu_mode_w;
    end
    cpu_viol = en && ((c_hit[SEL_SRC] || c_hit[SEL_DST]) ||
                      (c_hit[SEL_CTL] && (cpu_mode_w != mode)));
    dma_blk  = self_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      req  <= 1'b0;
      mode <= '0;
      src  <= '0;
      dst  <= '0;
      cnt  <= '0;
    end else begin
      if (ctl_we) begin
        en <= ctl_en_w;
        if (!en) mode <= ctl_mode_w;
      end
      if (req_set)                 req <= 1'b1;
      else if (ctl_we && !ctl_req_w) req <= 1'b0;

      if (d_hit[SEL_SRC])             src <= dma_wdata;
      else if (c_hit[SEL_SRC] && !en) src <= cpu_wdata;

      if (d_hit[SEL_DST])             dst <= dma_wdata;
      else if (c_hit[SEL_DST] && !en) dst <= cpu_wdata;

      if (!en) begin
        if (d_hit[SEL_CNT])      cnt <= dma_wdata;
        else if (c_hit[SEL_CNT]) cnt <= cpu_wdata;
      end
    end
  end

  // R4: the count is frozen across any cycle that starts enabled
  p_cnt_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(cnt));

  // R6: a hardware request always lands, whatever software wrote
  p_req_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_set |=> req);

  // R5: processor source write to an enabled channel has no effect
  p_cpu_src_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && en && cpu_sel == SEL_SRC && !dma_wr) |=> $stable(src));

  // R9: a channel cannot alter its own registers through the DMA port
  p_self_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (self_hit && !cpu_wr) |=>
      ($stable(src) && $stable(dst) && $stable(cnt) && $stable(mode) && $stable(en)));

  // R8: cross-channel address reload lands even when enabled
  p_dma_cross_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_wr && !self_hit && dma_sel == SEL_DST) |=> (dst == $past(dma_wdata)));

endmodule

// File: rtl/dmarb_status.sv
module dmarb_status
  import dmarb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_wr,
  input  logic [NCH-1:0]    irq_wdata,
  input  logic [NCH-1:0]    irq_set,
  input  logic              prot_wr,
  input  logic [PROT_W-1:0] prot_wdata,
  input  logic [NCH-1:0]    cpu_viol,
  input  logic [NCH-1:0]    dma_blk,
  output logic [NCH-1:0]    irq_status,
  output logic [PROT_W-1:0] prot
);

  logic [NCH-1:0]    irq_kept;
  logic [PROT_W-1:0] prot_kept;
  logic [PROT_W-1:0] prot_set;

  always_comb begin
    irq_kept  = irq_wr ? (irq_status & irq_wdata) : irq_status;
    prot_kept = prot_wr ? (prot & prot_wdata) : prot;
    prot_set               = '0;
    prot_set[PROT_CPU_BIT] = |cpu_viol;
    prot_set[PROT_DMA_BIT] = |dma_blk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_status <= '0;
      prot       <= '0;
    end else begin
      irq_status <= irq_kept | irq_set;
      prot       <= prot_kept | prot_set;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_irq_chk
    // R7: set event beats a same-cycle clear
    p_irq_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_set[i] |=> irq_status[i]);
    // R7: a status bit never rises without its event
    p_irq_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_status[i] && !irq_set[i]) |=> !irq_status[i]);
  end

  for (genvar b = 0; b < PROT_W; b++) begin : g_prot_chk
    // R10: protection bits are sticky until written with 0
    p_prot_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (prot[b] && !prot_wr) |=> prot[b]);
  end

endmodule

// File: rtl/dma_reg_bank.sv
module dma_reg_bank
  import dmarb_pkg::*;
#(
  parameter  int NCH    = 4,
  parameter  int REG_W  = 16,
  parameter  int MODE_W = 3,
  localparam int AW     = $clog2(NCH * REGS_PER_CH + 2),
  localparam int CW     = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [REG_W-1:0] cpu_wdata,
  input  logic             cpu_we,
  output logic [REG_W-1:0] cpu_rdata,
  input  logic [AW-1:0]    dma_addr,
  input  logic [REG_W-1:0] dma_wdata,
  input  logic             dma_we,
  input  logic [CW-1:0]    dma_ch,
  input  logic [NCH-1:0]   req_set,
  input  logic [NCH-1:0]   irq_set,
  output logic [NCH-1:0]   ch_enable,
  output logic [NCH-1:0]   ch_request,
  output logic             irq_pending
);

  logic          c_ch_hit, c_irq_hit, c_prot_hit;
  logic [CW-1:0] c_ch;
  reg_sel_e      c_sel;
  logic          d_ch_hit, d_irq_hit, d_prot_hit;
  logic [CW-1:0] d_ch;
  reg_sel_e      d_sel;

  dmarb_decode #(.NCH(NCH), .AW(AW), .CW(CW)) u_cpu_dec (
    .addr(cpu_addr), .ch_hit(c_ch_hit), .ch(c_ch), .sel(c_sel),
    .irq_hit(c_irq_hit), .prot_hit(c_prot_hit)
  );

  dmarb_decode #(.NCH(NCH), .AW(AW), .CW(CW)) u_dma_dec (
    .addr(dma_addr), .ch_hit(d_ch_hit), .ch(d_ch), .sel(d_sel),
    .irq_hit(d_irq_hit), .prot_hit(d_prot_hit)
  );

  logic [MODE_W-1:0] mode_q [NCH];
  logic [REG_W-1:0]  src_q  [NCH];
  logic [REG_W-1:0]  dst_q  [NCH];
  logic [REG_W-1:0]  cnt_q  [NCH];
  logic [NCH-1:0]    cpu_viol;
  logic [NCH-1:0]    dma_blk;
  logic [NCH-1:0]    irq_status;
  logic [PROT_W-1:0] prot_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic cpu_wr_g;
    logic dma_wr_g;
    assign cpu_wr_g = cpu_we && c_ch_hit && (c_ch == CW'(g));
    assign dma_wr_g = dma_we && d_ch_hit && (d_ch == CW'(g));

    dmarb_channel #(.IDX(g), .REG_W(REG_W), .MODE_W(MODE_W), .CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .cpu_wr(cpu_wr_g), .cpu_sel(c_sel), .cpu_wdata(cpu_wdata),
      .dma_wr(dma_wr_g), .dma_sel(d_sel), .dma_wdata(dma_wdata), .dma_ch(dma_ch),
      .req_set(req_set[g]),
      .en(ch_enable[g]), .req(ch_request[g]), .mode(mode_q[g]),
      .src(src_q[g]), .dst(dst_q[g]), .cnt(cnt_q[g]),
      .cpu_viol(cpu_viol[g]), .dma_blk(dma_blk[g])
    );
  end

  dmarb_status #(.NCH(NCH)) u_status (
    .clk(clk), .rst_n(rst_n),
    .irq_wr(cpu_we && c_irq_hit), .irq_wdata(cpu_wdata[NCH-1:0]), .irq_set(irq_set),
    .prot_wr(cpu_we && c_prot_hit), .prot_wdata(cpu_wdata[PROT_W-1:0]),
    .cpu_viol(cpu_viol), .dma_blk(dma_blk),
    .irq_status(irq_status), .prot(prot_q)
  );

  assign irq_pending = |irq_status;

  always_comb begin
    cpu_rdata = '0;
    if (c_ch_hit) begin
      unique case (c_sel)
        SEL_CTL: begin
          cpu_rdata[CTL_EN_BIT]              = ch_enable[c_ch];
          cpu_rdata[CTL_REQ_BIT]             = ch_request[c_ch];
          cpu_rdata[CTL_MODE_LSB +: MODE_W]  = mode_q[c_ch];
        end
        SEL_SRC: cpu_rdata = src_q[c_ch];
        SEL_DST: cpu_rdata = dst_q[c_ch];
        SEL_CNT: cpu_rdata = cnt_q[c_ch];
        default: cpu_rdata = '0;
      endcase
    end else if (c_irq_hit) begin
      cpu_rdata[NCH-1:0] = irq_status;
    end else if (c_prot_hit) begin
      cpu_rdata[PROT_W-1:0] = prot_q;
    end
  end

  // R9: a DMA-port write into the issuing channel's own window is flagged
  p_self_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_we && d_ch_hit && d_ch == dma_ch) |=> prot_q[PROT_DMA_BIT]);

  // R11: status words are not reachable from the DMA port
  p_dma_no_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_we && d_irq_hit && !(cpu_we && c_irq_hit) && irq_set == '0) |=> $stable(irq_status));

endmodule

// File: tb/dma_reg_bank_bench.sv
module dma_reg_bank_bench;

  localparam int CLK_P = 10;
  localparam int NCH   = 2;
  localparam int AW    = 4;
  localparam int IRQA  = 8;
  localparam int PROTA = 9;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] cpu_addr = 0, dma_addr = 0;
  logic [15:0]   cpu_wdata = 0, dma_wdata = 0, cpu_rdata;
  logic          cpu_we = 0, dma_we = 0;
  logic [0:0]    dma_ch = 0;
  logic [NCH-1:0] req_set = 0, irq_set = 0, ch_enable, ch_request;
  logic          irq_pending;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dma_reg_bank #(.NCH(NCH), .REG_W(16), .MODE_W(3)) u_dma_reg_bank (
    .clk, .rst_n, .cpu_addr, .cpu_wdata, .cpu_we, .cpu_rdata,
    .dma_addr, .dma_wdata, .dma_we, .dma_ch, .req_set, .irq_set,
    .ch_enable, .ch_request, .irq_pending
  );

  // behavioural reference state
  int m_en[NCH], m_req[NCH], m_mode[NCH], m_src[NCH], m_dst[NCH], m_cnt[NCH];
  int n_en[NCH], n_req[NCH], n_mode[NCH], n_src[NCH], n_dst[NCH], n_cnt[NCH];
  int m_irq, m_prot, n_irq, n_prot;

  task automatic apply(int c, int sel, int d, bit from_cpu);
    case (sel)
      0: begin
        n_en[c] = d & 1;
        if (((d >> 1) & 1) == 0) n_req[c] = 0;
        if (!m_en[c]) n_mode[c] = (d >> 2) & 7;
        else if (from_cpu && ((d >> 2) & 7) != m_mode[c]) n_prot |= 1;
      end
      1: if (!from_cpu || !m_en[c]) n_src[c] = d; else n_prot |= 1;
      2: if (!from_cpu || !m_en[c]) n_dst[c] = d; else n_prot |= 1;
      default: if (!m_en[c]) n_cnt[c] = d;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_en[c] = 0; m_req[c] = 0; m_mode[c] = 0;
        m_src[c] = 0; m_dst[c] = 0; m_cnt[c] = 0;
      end
      m_irq = 0; m_prot = 0;
    end else begin
      n_en = m_en; n_req = m_req; n_mode = m_mode;
      n_src = m_src; n_dst = m_dst; n_cnt = m_cnt;
      n_irq = m_irq; n_prot = m_prot;
      if (cpu_we && cpu_addr == IRQA)  n_irq  = m_irq & int'(cpu_wdata[1:0]);
      if (cpu_we && cpu_addr == PROTA) n_prot = m_prot & int'(cpu_wdata[1:0]);
      n_irq |= int'(irq_set);
      for (int c = 0; c < NCH; c++) begin
        bit dt, self, dok, ct;
        dt   = dma_we && dma_addr < 8 && (dma_addr / 4) == c;
        self = dt && (dma_ch == c);
        dok  = dt && !self;
        ct   = cpu_we && cpu_addr < 8 && (cpu_addr / 4) == c;
        if (self) n_prot |= 2;
        if (ct && !(dok && (dma_addr % 4) == (cpu_addr % 4)))
          apply(c, cpu_addr % 4, cpu_wdata, 1);
        if (dok) apply(c, dma_addr % 4, dma_wdata, 0);
        if (req_set[c]) n_req[c] = 1;
      end
      m_en = n_en; m_req = n_req; m_mode = n_mode;
      m_src = n_src; m_dst = n_dst; m_cnt = n_cnt;
      m_irq = n_irq; m_prot = n_prot;
    end
  end

  function automatic int model_read(int a);
    if (a < 8) begin
      case (a % 4)
        0: return m_en[a/4] | (m_req[a/4] << 1) | (m_mode[a/4] << 2);
        1: return m_src[a/4];
        2: return m_dst[a/4];
        default: return m_cnt[a/4];
      endcase
    end
    if (a == IRQA)  return m_irq;
    if (a == PROTA) return m_prot;
    return 0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int en_v, rq_v, ex;
      en_v = 0; rq_v = 0;
      for (int c = 0; c < NCH; c++) begin
        en_v |= m_en[c] << c;
        rq_v |= m_req[c] << c;
      end
      chk(int'(ch_enable) == en_v, "R3 enable", int'(ch_enable), en_v);
      chk(int'(ch_request) == rq_v, "R6 request", int'(ch_request), rq_v);
      chk(irq_pending == (m_irq != 0), "R7 irq_pending", int'(irq_pending), int'(m_irq != 0));
      ex = model_read(int'(cpu_addr));
      chk(int'(cpu_rdata) == ex, "R2 readback", int'(cpu_rdata), ex);
    end
  end

  task automatic cyc(bit cwe, int ca, int cd, bit dwe, int da, int dd, int dc, int rs, int is);
    @(negedge clk); #1;
    cpu_we = cwe; cpu_addr = AW'(ca); cpu_wdata = 16'(cd);
    dma_we = dwe; dma_addr = AW'(da); dma_wdata = 16'(dd); dma_ch = 1'(dc);
    req_set = NCH'(rs); irq_set = NCH'(is);
  endtask

  task automatic wr(int a, int d);
    cyc(1, a, d, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(int a, int exp, string tag);
    cyc(0, a, 0, 0, 0, 0, 0, 0, 0);
    #1;
    chk(int'(cpu_rdata) == exp, tag, int'(cpu_rdata), exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    rd(0, 'h0, "R1 ctl0 after reset");
    rd(7, 'h0, "R1 cnt1 after reset");
    rd(IRQA, 'h0, "R1 irq after reset");
    rd(PROTA, 'h0, "R1 prot after reset");
    // R2: disabled channel takes writes
    wr(1, 'h1234); rd(1, 'h1234, "R2 src0 disabled");
    wr(3, 'h000A); rd(3, 'h000A, "R2 cnt0 disabled");
    // R3: enable ch0 with mode 5
    wr(0, 'h15); rd(0, 'h15, "R3 enable ch0");
    chk(ch_enable == 2'b01, "R3 ch_enable", int'(ch_enable), 1);
    // R4: count locked
    wr(3, 'h55); rd(3, 'h000A, "R4 cnt locked");
    rd(PROTA, 'h0, "R4 no flag");
    // R5: src and mode guarded
    wr(1, 'hBEEF); rd(1, 'h1234, "R5 src guarded");
    rd(PROTA, 'h1, "R5 flag set");
    wr(0, 'h0D); rd(0, 'h15, "R5 mode kept");
    // R6: request flag
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0); rd(0, 'h17, "R6 req set");
    wr(0, 'h17); rd(0, 'h17, "R6 write 1 keeps");
    wr(0, 'h15); rd(0, 'h15, "R6 write 0 clears");
    cyc(1, 0, 'h15, 0, 0, 0, 0, 1, 0); rd(0, 'h17, "R6 set wins");
    wr(0, 'h15);
    // R7: interrupt status
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 3); rd(IRQA, 'h3, "R7 irq set");
    wr(IRQA, 'hFFFE); rd(IRQA, 'h2, "R7 clear bit0 only");
    cyc(1, IRQA, 0, 0, 0, 0, 0, 0, 1); rd(IRQA, 'h1, "R7 set wins");
    chk(irq_pending == 1, "R7 pending", int'(irq_pending), 1);
    wr(IRQA, 0); rd(IRQA, 'h0, "R7 cleared");
    // R8: cross-channel reload into enabled ch0
    cyc(0, 0, 0, 1, 1, 'h4444, 1, 0, 0); rd(1, 'h4444, "R8 cross src");
    cyc(0, 0, 0, 1, 2, 'h5555, 1, 0, 0); rd(2, 'h5555, "R8 cross dst");
    // R9: self write blocked
    cyc(0, 0, 0, 1, 2, 'h6666, 0, 0, 0); rd(2, 'h5555, "R9 self blocked");
    rd(PROTA, 'h3, "R9 flag set");
    // R10: protection word
    wr(PROTA, 'hFFFE); rd(PROTA, 'h2, "R10 clear bit0");
    cyc(1, PROTA, 0, 1, 0, 0, 0, 0, 0); rd(PROTA, 'h2, "R10 set wins");
    wr(PROTA, 0); rd(PROTA, 'h0, "R10 cleared");
    // R11: port collision, DMA rules on ctl/count, status unreachable
    cyc(1, 5, 'h8888, 1, 5, 'h7777, 0, 0, 0); rd(5, 'h7777, "R11 dma wins");
    cyc(0, 0, 0, 1, 3, 'h0BAD, 1, 0, 0); rd(3, 'h000A, "R11 dma cnt locked");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 1, IRQA, 0, 1, 0, 0); rd(IRQA, 'h1, "R11 dma irq ignored");
    wr(IRQA, 0);
    // disable and confirm count opens again
    wr(0, 'h14); rd(0, 'h14, "R3 disable ch0");
    wr(3, 'h55); rd(3, 'h55, "R4 cnt open when disabled");
    // random overlap phase, model compared every clock
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 3) == 0, $urandom % 11, $urandom,
          ($urandom % 4) == 0, $urandom % 12, $urandom, $urandom % 2,
          (($urandom % 6) == 0) ? ($urandom % 4) : 0,
          (($urandom % 6) == 0) ? ($urandom % 4) : 0);
    end
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk); #1;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule